// File: doc/BRIEF.md
# Dual-Clock FIFO with Configurable Synchronizers

This block is a first-in first-out buffer whose write port and read port run on two independent clocks. Each side keeps its own binary pointer. It converts that pointer to Gray code in a register and hands the Gray value across to the other side through a chain of flip-flop synchronizers. The receiving side converts the synchronized value back to binary. From it that side derives its flag and its used-words count. The storage is an array of inferred registers. Read data is registered and appears on the read clock edge that accepts the read.

Each crossing has its own synchronizer-depth parameter, and the value is offset-encoded: a setting of N builds N-2 flip-flop stages. The smallest setting is 3, which gives one stage. A setting of 4 gives two stages and is the least that protects against metastability. Setting `CLOCKS_SYNC` declares the two clocks synchronous and removes both chains.

Each used-words output passes through its own register pipeline, at least one stage deep. The pipeline adds latency to that output only. The `WIDE_COUNT` option makes both counts one bit wider, so that a full FIFO reports its depth instead of wrapping to zero.

Top module: `dual_clock_fifo`

## Requirements
- R1: While either reset is high, and after both resets are released with no traffic, `wr_full` is 0, `rd_empty` is 1, and `wr_used` and `rd_used` are 0.
- R2: Words leave on `rd_data` in the order they were accepted. A read accepted on a `rd_clk` edge updates `rd_data` on that same edge.
- R3: `wr_full` rises on the `wr_clk` edge that accepts the DEPTH-th unread word. A write presented while `wr_full` is 1 is ignored: the count does not move and the word never appears at the read port.
- R4: A read presented while `rd_empty` is 1 is ignored. `rd_data` holds its value, and the read pointer does not move, so the next word written is the next word read.
- R5: With `WIDE_COUNT`=1 the counts are ADDR_W+1 bits wide, and a full FIFO reports DEPTH (16 for ADDR_W=4). With `WIDE_COUNT`=0 the counts are ADDR_W bits wide, and a full FIFO reports 0.
- R6: `rd_used` passes through `RD_CNT_STAGES` registers. With 2 stages, after the `rd_clk` edge on which `rd_empty` falls, `rd_used` still reads 0 at the next two samples and reads 1 at the third.
- R7: `wr_used` passes through `WR_CNT_STAGES` registers. With 1 stage, `wr_used` reads the old value just after the accepting edge and the new value after the following `wr_clk` edge.
- R8: A synchronizer-depth setting of N builds N-2 stages, with a minimum of one. Each Gray pointer changes at most one bit per clock. Once writes stop, `rd_used` settles to the number of stored words.
- R9: The internal used-words value on either side never exceeds DEPTH, and the bench sees neither count above 16 during mixed traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side asynchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | FIFO full, write domain |
| wr_used | output | ADDR_W+WIDE_COUNT | Stored words as seen by the write side, pipelined |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Read-side asynchronous reset, active high |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered read word |
| rd_empty | output | 1 | FIFO empty, read domain |
| rd_used | output | ADDR_W+WIDE_COUNT | Stored words as seen by the read side, pipelined |

## Verification
The hardest case to reach from the ports is a FIFO that is truly at depth with its count settled on both sides. Only there does the wide count differ from the narrow one, and only there can a refused write be seen. The bench fills the buffer with no reads at all and waits many cycles of both clocks. It then compares a wide-count instance with a narrow-count instance driven by the same stimulus, and pushes one extra word that must never come out. The pipeline latency of the read count is pinned down by writing one word into an empty FIFO. The bench then counts `rd_clk` samples from the fall of `rd_empty` until `rd_used` turns to 1.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int N = (STAGES < 1) ? 1 : STAGES;

    logic [W-1:0] ff [N];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ff[i] <= '0;
        end else begin
            ff[0] <= d;
            for (int i = 1; i < N; i++) ff[i] <= ff[i-1];
        end
    end

    assign q = ff[N-1];
endmodule

// File: rtl/dcf_cnt_pipe.sv
module dcf_cnt_pipe #(
    parameter int W      = 4,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int N = (STAGES < 1) ? 1 : STAGES;

    logic [W-1:0] st [N];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < N; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < N; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[N-1];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [AW:0] rq_gray,
    output logic [AW:0] ptr,
    output logic [AW:0] gray,
    output logic [AW:0] cnt_raw,
    output logic        full,
    output logic        push
);
    localparam int PW = AW + 1;
    localparam logic [AW:0] DEPTH_V = PW'(1) << AW;

    logic [AW:0] rq_bin;
    logic [AW:0] ptr_nx;

    assign rq_bin  = PW'(gray_to_bin(32'(rq_gray)));
    assign cnt_raw = ptr - rq_bin;
    assign full    = (cnt_raw == DEPTH_V);
    assign push    = wr_en & ~full;
    assign ptr_nx  = ptr + PW'(push);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ptr  <= '0;
            gray <= '0;
        end else begin
            ptr  <= ptr_nx;
            gray <= PW'(bin_to_gray(32'(ptr_nx)));
        end
    end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en,
    input  logic [AW:0] wq_gray,
    output logic [AW:0] ptr,
    output logic [AW:0] gray,
    output logic [AW:0] cnt_raw,
    output logic        empty,
    output logic        pop
);
    localparam int PW = AW + 1;

    logic [AW:0] wq_bin;
    logic [AW:0] ptr_nx;

    assign wq_bin  = PW'(gray_to_bin(32'(wq_gray)));
    assign cnt_raw = wq_bin - ptr;
    assign empty   = (cnt_raw == '0);
    assign pop     = rd_en & ~empty;
    assign ptr_nx  = ptr + PW'(pop);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ptr  <= '0;
            gray <= '0;
        end else begin
            ptr  <= ptr_nx;
            gray <= PW'(bin_to_gray(32'(ptr_nx)));
        end
    end
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          push,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          pop,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (push) mem[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk or posedge rd_rst) begin
        if (rd_rst)   rdata <= '0;
        else if (pop) rdata <= mem[raddr];
    end
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
    parameter int DATA_W        = 8,
    parameter int ADDR_W        = 4,
    parameter int W2R_SYNC_CODE = 4,
    parameter int R2W_SYNC_CODE = 4,
    parameter int CLOCKS_SYNC   = 0,
    parameter int RD_CNT_STAGES = 1,
    parameter int WR_CNT_STAGES = 1,
    parameter int WIDE_COUNT    = 0,
    localparam int CNT_W        = ADDR_W + ((WIDE_COUNT != 0) ? 1 : 0)
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic [CNT_W-1:0]  wr_used,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic [CNT_W-1:0]  rd_used
);
    localparam int PW         = ADDR_W + 1;
    localparam int W2R_STAGES = (W2R_SYNC_CODE > 3) ? W2R_SYNC_CODE - 2 : 1;
    localparam int R2W_STAGES = (R2W_SYNC_CODE > 3) ? R2W_SYNC_CODE - 2 : 1;

    logic [PW-1:0] w_ptr, w_gray, w_cnt_raw;
    logic [PW-1:0] r_ptr, r_gray, r_cnt_raw;
    logic [PW-1:0] rq_gray, wq_gray;
    logic          w_push, r_pop;

    dcf_wr_side #(.AW(ADDR_W)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .rq_gray(rq_gray),
        .ptr(w_ptr), .gray(w_gray), .cnt_raw(w_cnt_raw),
        .full(wr_full), .push(w_push)
    );

    dcf_rd_side #(.AW(ADDR_W)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .wq_gray(wq_gray),
        .ptr(r_ptr), .gray(r_gray), .cnt_raw(r_cnt_raw),
        .empty(rd_empty), .pop(r_pop)
    );

    generate
        if (CLOCKS_SYNC != 0) begin : g_direct
            assign wq_gray = w_gray;
            assign rq_gray = r_gray;
        end else begin : g_cross
            dcf_sync #(.W(PW), .STAGES(W2R_STAGES)) u_w2r (
                .clk(rd_clk), .rst(rd_rst), .d(w_gray), .q(wq_gray)
            );
            dcf_sync #(.W(PW), .STAGES(R2W_STAGES)) u_r2w (
                .clk(wr_clk), .rst(wr_rst), .d(r_gray), .q(rq_gray)
            );
        end
    endgenerate

    dcf_store #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wr_clk(wr_clk), .push(w_push), .waddr(w_ptr[ADDR_W-1:0]), .wdata(wr_data),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .pop(r_pop), .raddr(r_ptr[ADDR_W-1:0]),
        .rdata(rd_data)
    );

    dcf_cnt_pipe #(.W(CNT_W), .STAGES(WR_CNT_STAGES)) u_wcnt (
        .clk(wr_clk), .rst(wr_rst), .d(w_cnt_raw[CNT_W-1:0]), .q(wr_used)
    );

    dcf_cnt_pipe #(.W(CNT_W), .STAGES(RD_CNT_STAGES)) u_rcnt (
        .clk(rd_clk), .rst(rd_rst), .d(r_cnt_raw[CNT_W-1:0]), .q(rd_used)
    );
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          wr_en,
    input logic          wr_full,
    input logic          rd_en,
    input logic          rd_empty,
    input logic [AW:0]   wptr,
    input logic [AW:0]   rptr,
    input logic [AW:0]   wgray,
    input logic [AW:0]   rgray,
    input logic [AW:0]   wcnt,
    input logic [AW:0]   rcnt,
    input logic [DW-1:0] rdata
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(1) << AW;

    // R3: a refused write leaves the write pointer where it was
    a_r3_full_write_ignored: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && wr_full) |=> (wptr == $past(wptr)));

    // R4: a refused read leaves the pointer and the data register alone
    a_r4_empty_read_ignored: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && rd_empty) |=> (rptr == $past(rptr) && rdata == $past(rdata)));

    // R8: each Gray pointer moves by at most one bit per clock
    a_r8_wgray_one_bit: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $onehot0(wgray ^ $past(wgray)));

    a_r8_rgray_one_bit: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $onehot0(rgray ^ $past(rgray)));

    // R9: neither side ever sees more than DEPTH words
    a_r9_wcnt_bound: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wcnt <= DEPTH_V);

    a_r9_rcnt_bound: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rcnt <= DEPTH_V);
endmodule

bind dual_clock_fifo dcf_checker #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .wr_en(wr_en), .wr_full(wr_full), .rd_en(rd_en), .rd_empty(rd_empty),
    .wptr(w_ptr), .rptr(r_ptr), .wgray(w_gray), .rgray(r_gray),
    .wcnt(w_cnt_raw), .rcnt(r_cnt_raw), .rdata(rd_data)
);

// File: tb/tb_dual_clock_fifo.sv
`timescale 1ns/1ps
module tb_dual_clock_fifo;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst = 1, rd_rst = 1;
    logic wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic wr_full, rd_empty, n_wr_full, n_rd_empty;
    logic [AW:0] wr_used, rd_used;
    logic [AW-1:0] n_wr_used, n_rd_used;
    logic [DW-1:0] rd_data, n_rd_data;

    int checks = 0, failures = 0;
    logic [DW-1:0] model [$];

    always #2.0 wr_clk = ~wr_clk;   // 250 MHz
    always #3.5 rd_clk = ~rd_clk;

    dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW), .W2R_SYNC_CODE(4), .R2W_SYNC_CODE(4),
        .RD_CNT_STAGES(2), .WR_CNT_STAGES(1), .WIDE_COUNT(1)) dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_used(wr_used), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty), .rd_used(rd_used));

    dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW), .W2R_SYNC_CODE(4), .R2W_SYNC_CODE(4),
        .RD_CNT_STAGES(2), .WR_CNT_STAGES(1), .WIDE_COUNT(0)) dut_narrow (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(n_wr_full), .wr_used(n_wr_used), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .rd_en(rd_en), .rd_data(n_rd_data), .rd_empty(n_rd_empty), .rd_used(n_rd_used));

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] v, output bit accepted);
        @(negedge wr_clk);
        accepted = !wr_full;
        wr_en = 1; wr_data = v;
        if (accepted) model.push_back(v);
        @(posedge wr_clk); #1;
        wr_en = 0;
    endtask

    task automatic pop(input string req);
        bit acc;
        logic [DW-1:0] exp;
        @(negedge rd_clk);
        acc = !rd_empty;
        rd_en = 1;
        @(posedge rd_clk); #1;
        rd_en = 0;
        if (acc) begin
            exp = model.pop_front();
            check(req, "rd_data order", int'(rd_data), int'(exp));
        end else begin
            check(req, "pop refused unexpectedly", 0, 1);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge rd_clk);
        repeat (n) @(negedge wr_clk);
    endtask

    task automatic t_reset;
        #1;
        check("R1", "wr_full in reset", int'(wr_full), 0);
        check("R1", "rd_empty in reset", int'(rd_empty), 1);
        #40; wr_rst = 0; rd_rst = 0;
        idle(4);
        check("R1", "wr_full after reset", int'(wr_full), 0);
        check("R1", "rd_empty after reset", int'(rd_empty), 1);
        check("R1", "wr_used after reset", int'(wr_used), 0);
        check("R1", "rd_used after reset", int'(rd_used), 0);
    endtask

    task automatic t_fill_drain;
        bit acc;
        logic [DW-1:0] last;
        push(8'h10, acc);
        check("R7", "wr_used just after accept", int'(wr_used), 0);
        @(posedge wr_clk); #1;
        check("R7", "wr_used one edge later", int'(wr_used), 1);
        for (int i = 1; i < DEPTH; i++) begin
            push(8'(8'h10 + i), acc);
            if (i == DEPTH - 1) check("R3", "wr_full on DEPTH-th word", int'(wr_full), 1);
        end
        idle(30);
        check("R5", "wide wr_used at full", int'(wr_used), DEPTH);
        check("R5", "narrow wr_used at full", int'(n_wr_used), 0);
        check("R5", "narrow wr_full", int'(n_wr_full), 1);
        check("R8", "rd_used settles to stored count", int'(rd_used), DEPTH);
        push(8'hEE, acc);
        check("R3", "write while full refused", int'(acc), 0);
        idle(3);
        check("R3", "wr_used unchanged after refused write", int'(wr_used), DEPTH);
        for (int i = 0; i < DEPTH; i++) pop("R2");
        last = rd_data;
        idle(30);
        check("R3", "no extra word after drain", int'(rd_empty), 1);
        @(negedge rd_clk); rd_en = 1;
        @(posedge rd_clk); #1; rd_en = 0;
        idle(2);
        check("R4", "rd_data holds on empty read", int'(rd_data), int'(last));
        check("R4", "still empty after refused read", int'(rd_empty), 1);
    endtask

    task automatic t_latency;
        bit acc;
        int guard = 0;
        push(8'h5A, acc);
        @(negedge rd_clk);
        while (rd_empty && guard < 100) begin
            @(negedge rd_clk); guard++;
        end
        check("R6", "rd_empty fell", int'(rd_empty), 0);
        check("R6", "rd_used at empty fall", int'(rd_used), 0);
        @(negedge rd_clk);
        check("R6", "rd_used one edge later", int'(rd_used), 0);
        @(negedge rd_clk);
        check("R6", "rd_used two edges later", int'(rd_used), 1);
        pop("R4");
    endtask

    task automatic t_stream;
        int n_wr = 0, n_rd = 0, bad_cnt = 0;
        fork
            begin
                while (n_wr < 120) begin
                    @(negedge wr_clk);
                    if (wr_used > DEPTH) bad_cnt++;
                    if (!wr_full && ($urandom % 4 != 0)) begin
                        wr_en = 1; wr_data = 8'(n_wr * 7 + 3);
                        model.push_back(wr_data); n_wr++;
                    end else wr_en = 0;
                end
                @(negedge wr_clk); wr_en = 0;
            end
            begin
                bit pend = 0;
                logic [DW-1:0] exp;
                while (n_rd < 120) begin
                    @(negedge rd_clk);
                    if (rd_used > DEPTH) bad_cnt++;
                    if (pend) begin
                        exp = model.pop_front();
                        check("R2", "stream rd_data", int'(rd_data), int'(exp));
                        n_rd++;
                    end
                    pend = 0;
                    if (!rd_empty && ($urandom % 3 != 0) && n_rd < 120) begin
                        rd_en = 1; pend = 1;
                    end else rd_en = 0;
                end
                rd_en = 0;
            end
        join
        check("R9", "counts within depth", bad_cnt, 0);
        idle(30);
        check("R2", "empty after stream", int'(rd_empty), 1);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_drain();
        t_latency();
        t_stream();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule